// File: doc/BRIEF.md
# Torus Dateline Route and Level Selector

This block makes the per-hop routing decision for a wormhole packet travelling through a unidirectional torus. The torus has `N_DIM` dimensions and `RADIX` nodes per ring, and every ring has a wraparound link. The block receives the coordinates of the current node, the destination coordinates, and two values carried in the packet header: the dimension the packet is being routed in and its current virtual channel level. One clock later it returns the dimension of the next hop, or a request to eject the packet at the local port, together with the virtual channel level to use on the outgoing link.

Dimensions are resolved in ascending order. A packet never returns to a lower dimension. Links only move the coordinate upward, and a ring closes from the highest coordinate back to zero. Crossing that closing link creates a cyclic channel dependency that can deadlock wormhole traffic. To break the cycle, the block moves the packet to the next higher virtual channel level on every such crossing. Channel use then follows a strictly increasing numbering. A packet is injected at level 0, so `N_DIM + 1` levels are enough. Deadlock freedom also relies on the destination always draining the packets that arrive there.

Top module: `tdr_route_unit`

## Requirements
- R1: After reset, and until the first accepted request, `out_valid` is 0.
- R2: Each cycle with `in_valid` high produces exactly one result, with `out_valid` high, on the following cycle. A cycle with `in_valid` low produces `out_valid` low on the following cycle.
- R3: The result dimension `out_dim` is the lowest index `d` with `d >= hdr_dim` for which the current and destination coordinate fields differ. Coordinate field `d` occupies bits `[d*CW +: CW]` of the coordinate vectors.
- R4: If no dimension from `hdr_dim` upward differs, then `out_eject` is 1, `out_dim` is 0, `out_lvl` equals `hdr_lvl`, and `out_err` is 0.
- R5: For a hop whose current coordinate in the selected dimension is below `RADIX-1`, `out_lvl` equals `hdr_lvl` and `out_err` is 0.
- R6: For a hop whose current coordinate in the selected dimension equals `RADIX-1` (a wraparound to 0), `out_lvl` is `hdr_lvl + 1` when `hdr_lvl < N_DIM`.
- R7: `out_lvl` is never below the request's `hdr_lvl` and never above `N_DIM`.
- R8: A wraparound hop with `hdr_lvl == N_DIM` raises `out_err`, and `out_lvl` stays at `N_DIM`. `out_eject` is 0 for such a hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| here_xyz | input | N_DIM*CW | Current node coordinates, field d at [d*CW +: CW] |
| dest_xyz | input | N_DIM*CW | Destination coordinates, same packing |
| hdr_dim | input | DW | Dimension recorded in the header |
| hdr_lvl | input | LW | Virtual channel level recorded in the header |
| out_valid | output | 1 | Result present |
| out_dim | output | DW | Dimension of the next hop |
| out_eject | output | 1 | Deliver to the local port |
| out_lvl | output | LW | Level for the outgoing link |
| out_err | output | 1 | Level increment would exceed N_DIM |

## Verification
The assertions take two things for granted about each request. Its header level is at most `N_DIM`, and every coordinate below `hdr_dim` already matches the destination, since dimension order guarantees that upstream. The bench builds every destination by copying the current coordinates into all dimensions below the header dimension and draws header levels only from 0 to `N_DIM`. Within those limits it drives directed wraparound, saturation and ejection cases as well as seeded random requests, both back to back and with idle gaps.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {
    HOP_EJECT    = 2'd0,
    HOP_STRAIGHT = 2'd1,
    HOP_WRAP     = 2'd2,
    HOP_OVERRUN  = 2'd3
  } hop_kind_e;
endpackage

// File: rtl/tdr_dim_scan.sv
module tdr_dim_scan #(
  parameter int N_DIM = 3,
  parameter int CW    = 2,
  parameter int DW    = 2
) (
  input  logic [N_DIM*CW-1:0] here_xyz,
  input  logic [N_DIM*CW-1:0] dest_xyz,
  input  logic [DW-1:0]       start_dim,
  output logic                found,
  output logic [DW-1:0]       sel_dim
);
  logic [N_DIM-1:0] pending;

  generate
    for (genvar d = 0; d < N_DIM; d++) begin : g_cmp
      assign pending[d] = (here_xyz[d*CW +: CW] != dest_xyz[d*CW +: CW])
                          && (d >= int'(start_dim));
    end
  endgenerate

  // lowest pending dimension wins: scan from the top so the last hit sticks
  always_comb begin
    found   = 1'b0;
    sel_dim = '0;
    for (int d = N_DIM - 1; d >= 0; d--) begin
      if (pending[d]) begin
        found   = 1'b1;
        sel_dim = DW'(d);
      end
    end
  end
endmodule

// File: rtl/tdr_level_step.sv
module tdr_level_step
  import tdr_pkg::*;
#(
  parameter int N_DIM = 3,
  parameter int RADIX = 4,
  parameter int CW    = 2,
  parameter int LW    = 3
) (
  input  logic          found,
  input  logic [CW-1:0] coord,
  input  logic [LW-1:0] lvl_in,
  output hop_kind_e     kind,
  output logic          wraps,
  output logic [LW-1:0] lvl_out
);
  localparam logic [CW-1:0] EDGE = CW'(RADIX - 1);
  localparam logic [LW-1:0] TOP  = LW'(N_DIM);

  function automatic hop_kind_e classify(input logic f, input logic [CW-1:0] c,
                                         input logic [LW-1:0] l);
    if (!f)            return HOP_EJECT;
    else if (c != EDGE) return HOP_STRAIGHT;
    else if (l >= TOP)  return HOP_OVERRUN;
    else                return HOP_WRAP;
  endfunction

  assign wraps = found && (coord == EDGE);
  assign kind  = classify(found, coord, lvl_in);

  always_comb begin
    unique case (kind)
      HOP_WRAP:    lvl_out = lvl_in + LW'(1);
      HOP_OVERRUN: lvl_out = TOP;
      default:     lvl_out = lvl_in;
    endcase
  end
endmodule

// File: rtl/tdr_route_unit.sv
module tdr_route_unit
  import tdr_pkg::*;
#(
  parameter int N_DIM = 3,
  parameter int RADIX = 4,
  localparam int CW = (RADIX > 2) ? $clog2(RADIX) : 1,
  localparam int DW = (N_DIM > 2) ? $clog2(N_DIM) : 1,
  localparam int LW = $clog2(N_DIM + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [N_DIM*CW-1:0] here_xyz,
  input  logic [N_DIM*CW-1:0] dest_xyz,
  input  logic [DW-1:0]       hdr_dim,
  input  logic [LW-1:0]       hdr_lvl,
  output logic                out_valid,
  output logic [DW-1:0]       out_dim,
  output logic                out_eject,
  output logic [LW-1:0]       out_lvl,
  output logic                out_err
);
  logic          scan_found;
  logic [DW-1:0] scan_dim;
  logic [CW-1:0] act_coord;
  hop_kind_e     hop_kind;
  logic          hop_wraps;
  logic [LW-1:0] next_lvl;

  tdr_dim_scan #(.N_DIM(N_DIM), .CW(CW), .DW(DW)) u_scan (
    .here_xyz (here_xyz),
    .dest_xyz (dest_xyz),
    .start_dim(hdr_dim),
    .found    (scan_found),
    .sel_dim  (scan_dim)
  );

  assign act_coord = here_xyz[scan_dim*CW +: CW];

  tdr_level_step #(.N_DIM(N_DIM), .RADIX(RADIX), .CW(CW), .LW(LW)) u_lvl (
    .found  (scan_found),
    .coord  (act_coord),
    .lvl_in (hdr_lvl),
    .kind   (hop_kind),
    .wraps  (hop_wraps),
    .lvl_out(next_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dim   <= '0;
      out_eject <= 1'b0;
      out_lvl   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dim   <= scan_dim;
        out_eject <= (hop_kind == HOP_EJECT);
        out_lvl   <= next_lvl;
        out_err   <= (hop_kind == HOP_OVERRUN);
      end
    end
  end

  // input assumption: header level within 0..N_DIM (R7)
  a_r7_in_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> hdr_lvl <= LW'(N_DIM));

  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lvl <= LW'(N_DIM));

  a_r7_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_lvl >= $past(hdr_lvl));

  a_r4_eject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !scan_found |=> out_eject && !out_err && out_lvl == $past(hdr_lvl));

  a_r6_wrap_bump: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hop_wraps && hdr_lvl < LW'(N_DIM) |=> out_lvl == $past(hdr_lvl) + LW'(1));

  a_r5_straight_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && scan_found && !hop_wraps |=> out_lvl == $past(hdr_lvl) && !out_err);

  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_lvl == LW'(N_DIM) && !out_eject);
endmodule

// File: tb/sim_tdr_route_unit.sv
module sim_tdr_route_unit;
  localparam int N_DIM = 3;
  localparam int RADIX = 4;
  localparam int CW = 2;
  localparam int DW = 2;
  localparam int LW = 3;

  typedef struct {
    int          stamp;
    logic [DW-1:0] dim;
    logic        ej;
    logic [LW-1:0] lvl;
    logic        err;
    logic [LW-1:0] in_lvl;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N_DIM*CW-1:0] here_xyz = '0, dest_xyz = '0;
  logic [DW-1:0] hdr_dim = '0;
  logic [LW-1:0] hdr_lvl = '0;
  logic out_valid, out_eject, out_err;
  logic [DW-1:0] out_dim;
  logic [LW-1:0] out_lvl;

  int cyc = 0, checks = 0, fails = 0;
  exp_t q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdr_route_unit #(.N_DIM(N_DIM), .RADIX(RADIX)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .here_xyz(here_xyz),
    .dest_xyz(dest_xyz), .hdr_dim(hdr_dim), .hdr_lvl(hdr_lvl),
    .out_valid(out_valid), .out_dim(out_dim), .out_eject(out_eject),
    .out_lvl(out_lvl), .out_err(out_err));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // model: walk dimensions top down, remember the last (lowest) mismatch
  function automatic exp_t model(input logic [N_DIM*CW-1:0] h, input logic [N_DIM*CW-1:0] t,
                                 input int dim0, input int lvl);
    exp_t e;
    int pick = -1;
    for (int d = N_DIM - 1; d >= dim0; d--)
      if (h[d*CW +: CW] != t[d*CW +: CW]) pick = d;
    e.in_lvl = LW'(lvl);
    e.err = 1'b0;
    if (pick < 0) begin
      e.ej = 1'b1; e.dim = '0; e.lvl = LW'(lvl);
    end else begin
      e.ej = 1'b0; e.dim = DW'(pick);
      if (int'(h[pick*CW +: CW]) == RADIX - 1) begin
        if (lvl == N_DIM) begin e.err = 1'b1; e.lvl = LW'(N_DIM); end
        else e.lvl = LW'(lvl + 1);
      end else e.lvl = LW'(lvl);
    end
    return e;
  endfunction

  task automatic send(input logic [N_DIM*CW-1:0] h, input logic [N_DIM*CW-1:0] t,
                      input int dim0, input int lvl);
    exp_t e;
    e = model(h, t, dim0, lvl);
    e.stamp = cyc;
    here_xyz = h; dest_xyz = t; hdr_dim = DW'(dim0); hdr_lvl = LW'(lvl);
    in_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N_DIM*CW-1:0] pack3(input int x, input int y, input int z);
    return {CW'(z), CW'(y), CW'(x)};
  endfunction

  // monitor: pop and compare at the negedge after capture
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].stamp == cyc - 1) begin
        exp_t e;
        e = q.pop_front();
        check("R2 out_valid", int'(out_valid), 1);
        check("R3 out_dim", int'(out_dim), int'(e.dim));
        check("R4 out_eject", int'(out_eject), int'(e.ej));
        check("R6 out_lvl", int'(out_lvl), int'(e.lvl));
        check("R8 out_err", int'(out_err), int'(e.err));
        checks++;
        if (out_lvl < e.in_lvl || int'(out_lvl) > N_DIM) begin
          fails++;
          $display("FAIL R7 level range: actual %0d expected %0d..%0d", out_lvl, e.in_lvl, N_DIM);
        end
      end else begin
        check("R2 idle out_valid", int'(out_valid), 0);
        if (q.size() > 0 && q[0].stamp < cyc - 1) begin
          void'(q.pop_front());
          fails++;
          $display("FAIL R2 missing result: actual 0 expected 1");
        end
      end
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset out_valid", int'(out_valid), 0);

    send(pack3(1, 2, 3), pack3(1, 2, 3), 0, 0);   // R4 eject
    send(pack3(1, 0, 0), pack3(2, 0, 0), 0, 0);   // R5 straight in X
    send(pack3(3, 0, 0), pack3(1, 0, 0), 0, 0);   // R6 wrap in X
    send(pack3(2, 3, 1), pack3(2, 0, 2), 0, 1);   // R3 skip X, wrap in Y
    send(pack3(2, 2, 3), pack3(2, 2, 0), 1, 3);   // R8 overrun in Z
    send(pack3(0, 0, 3), pack3(0, 0, 1), 2, 2);   // R6 wrap to top level
    send(pack3(0, 1, 2), pack3(0, 1, 2), 2, 3);   // R4 eject at top level
    idle(3);
    send(pack3(3, 3, 3), pack3(0, 0, 0), 0, 3);   // R8 overrun in X
    send(pack3(1, 1, 0), pack3(1, 1, 3), 2, 1);   // R5 straight in Z
    idle(1);

    for (int i = 0; i < 300; i++) begin
      int dim0, lvl;
      logic [N_DIM*CW-1:0] h, t;
      dim0 = $urandom_range(0, N_DIM - 1);
      lvl  = $urandom_range(0, N_DIM);
      h = N_DIM*CW'($urandom);
      t = N_DIM*CW'($urandom);
      for (int d = 0; d < dim0; d++) t[d*CW +: CW] = h[d*CW +: CW];
      send(h, t, dim0, lvl);
      if (i % 7 == 0) idle(i % 3);
    end
    idle(4);
    check("R2 queue drained", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule